// File: doc/BRIEF.md
# Tagged shared-bus register access port

This block is the slave end of a narrow host control port. An external host reaches a small bank of 8-bit configuration and status registers over a single 10-bit shared bus. The host supplies the port clock. The low eight bus bits carry either a register address or a data byte. The top two bits are a phase tag that says which of the two the word is. A mode input chooses between this control path and an unrelated ancillary path. A direction input chooses read or write.

Every access takes two port-clock edges. The first edge captures an address. On a read, the block then drives the selected register, tagged as read data, for one clock period. On a write, the host presents a tagged data byte, and the second edge stores it. After any reset the port ignores the bus for a fixed number of warm-up edges. Any phase carrying the wrong tag aborts the access and sets a sticky error flag, which the host can read back. The bus is modelled as separate input, output and output-enable signals, so that the tri-state buffer can sit at the pad.

Top module: `regport_top`

## Requirements
- R1: While reset (rst_n low at a rising edge) is applied, bus_oe is 0, bus_out is 0, test_ctrl is 0x00, and every register reads 0x00 afterwards, except for the live flags at address 0x01.
- R2: The first three rising edges after reset is released are ignored, whatever is on the bus. The fourth edge can start an access.
- R3: A read starts when sel_anc=0, dir_rd=1 and bus_in[9:8]=00 at a rising edge, and bus_in[7:0] gives the address. Right after that edge, bus_oe=1 and bus_out={2'b10, register}. This value holds until the next rising edge, which returns bus_oe and bus_out to 0.
- R4: A write starts when sel_anc=0, dir_rd=0 and bus_in[9:8]=00 at an edge, which captures the address. At the next edge, a word with bus_in[9:8]=11 stores bus_in[7:0] into writable registers 0x02..0x0F. The output test_ctrl always equals register 0x0D, so writing 0x27 there shows 0x27 and changes nothing else.
- R5: Reading a register does not change its contents. Repeated reads return the same value.
- R6: Address 0x00 reads {7'b0, error flag}. Address 0x01 reads {3'b0, stat_flags}, sampled at the address edge. Both are read-only, and writes to them are ignored.
- R7: Addresses 0x10..0xFF are unimplemented. They read 0x00, and writes to them are ignored. They do not alias onto low registers.
- R8: While sel_anc=1, the port ignores the bus. Any pending write is dropped without a store, bus_oe stays 0, and the error flag is not set.
- R9: An address phase whose tag is not 00, or a data phase whose tag is not 11, stores nothing and returns the port to idle. It sets the error flag (address 0x00 bit 0), which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host-supplied port clock; all activity on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_anc | input | 1 | 1 = ancillary path selected, control port idle; 0 = control access |
| dir_rd | input | 1 | 1 = read access, 0 = write access |
| bus_in | input | 10 | Shared bus as seen at the pad: [9:8] tag, [7:0] address or data |
| bus_out | output | 10 | Value driven onto the shared bus during a read |
| bus_oe | output | 1 | Output enable for the pad driver of the shared bus |
| stat_flags | input | 5 | Live status flags returned at address 0x01 |
| test_ctrl | output | 8 | Current content of test-control register 0x0D |

## Verification
The assertions assume that the host holds sel_anc at 1 whenever no access is in progress. They also assume that the host never presents the next address in the same cycle as the edge that releases the bus after a read. The stimulus tasks therefore return to sel_anc=1 with a zeroed bus after every access. The host's own tags and direction are changed only at falling edges. Wrong tags and a mid-write switch to sel_anc=1 are used only deliberately, in the tests for R8 and R9. stat_flags is held constant across each read, so the sampled value is known.

// File: rtl/regport_pkg.sv
// Package: shared constants and the phase-sequencer state type of the
// tagged register port. Assumes a 2-bit phase tag on the upper bus bits.
package regport_pkg;

    localparam int TAG_W = 2;

    localparam logic [TAG_W-1:0] TAG_ADDR  = 2'b00;
    localparam logic [TAG_W-1:0] TAG_WDATA = 2'b11;
    localparam logic [TAG_W-1:0] TAG_RDATA = 2'b10;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DRIVE = 2'd1,
        PH_WDATA = 2'd2
    } phase_t;

endpackage

// File: rtl/regport_init.sv
// Module: post-reset warm-up counter. Counts rising edges after reset is
// released and raises ready once INIT_EDGES of them have passed.
// Assumes a synchronous active-low reset on the port clock.
module regport_init #(
    parameter int INIT_EDGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready_o
);
    localparam int CNT_W = $clog2(INIT_EDGES + 1);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(INIT_EDGES);

    logic [CNT_W-1:0] cnt_q;

    // Count warm-up edges, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_DONE) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ready_o = (cnt_q == CNT_DONE);

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o); // R2

endmodule

// File: rtl/regport_fsm.sv
// Module: phase sequencer. Checks the tag of each bus word, captures the
// address, snapshots read data and drives it for one period, and issues
// a single write strobe on a correctly tagged data phase.
// Assumes the host keeps sel_anc high between accesses.
module regport_fsm
    import regport_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ready_i,
    input  logic                    sel_anc,
    input  logic                    dir_rd,
    input  logic [TAG_W+DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0]       rd_data_i,
    output logic [DATA_W-1:0]       raddr_o,
    output logic                    we_o,
    output logic [DATA_W-1:0]       waddr_o,
    output logic [DATA_W-1:0]       wdata_o,
    output logic                    err_o,
    output logic [TAG_W+DATA_W-1:0] bus_out,
    output logic                    bus_oe
);
    phase_t            st_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] rd_q;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] payload;

    assign tag     = bus_in[TAG_W+DATA_W-1:DATA_W];
    assign payload = bus_in[DATA_W-1:0];

    // Advance the access phase and capture address and read snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= PH_IDLE;
            addr_q <= '0;
            rd_q   <= '0;
        end else if (sel_anc) begin
            st_q <= PH_IDLE;
        end else begin
            case (st_q)
                PH_IDLE: begin
                    if (ready_i && tag == TAG_ADDR) begin
                        addr_q <= payload;
                        rd_q   <= rd_data_i;
                        st_q   <= dir_rd ? PH_DRIVE : PH_WDATA;
                    end
                end
                PH_DRIVE: st_q <= PH_IDLE;
                PH_WDATA: st_q <= PH_IDLE;
                default:  st_q <= PH_IDLE;
            endcase
        end
    end

    // Decode write strobe and tag errors for the current bus word.
    always_comb begin
        we_o  = 1'b0;
        err_o = 1'b0;
        if (!sel_anc) begin
            if (st_q == PH_IDLE && ready_i && tag != TAG_ADDR) begin
                err_o = 1'b1;
            end
            if (st_q == PH_WDATA) begin
                if (tag == TAG_WDATA) begin
                    we_o = 1'b1;
                end else begin
                    err_o = 1'b1;
                end
            end
        end
    end

    assign raddr_o = payload;
    assign waddr_o = addr_q;
    assign wdata_o = payload;
    assign bus_oe  = (st_q == PH_DRIVE);
    assign bus_out = bus_oe ? {TAG_RDATA, rd_q} : '0;

    AST_NO_EARLY_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> !bus_oe); // R2
    AST_DRIVE_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |=> !bus_oe); // R3
    AST_ANC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sel_anc |=> !bus_oe); // R8
    AST_ANC_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_anc |-> !we_o && !err_o); // R8
    AST_WRITE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> $past(!sel_anc && !dir_rd && tag == TAG_ADDR)); // R4

endmodule

// File: rtl/regport_bank.sv
// Module: register bank. Holds NREG byte registers. Address 0 is the
// sticky error flag and address 1 the live status flags, both read-only.
// The remaining registers are host-writable. Out-of-range addresses read
// zero. Assumes at most one write strobe per clock.
module regport_bank #(
    parameter int DATA_W    = 8,
    parameter int NREG      = 16,
    parameter int FLAG_W    = 5,
    parameter int TEST_ADDR = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              err_i,
    input  logic [DATA_W-1:0] raddr_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [DATA_W-1:0] test_ctrl_o
);
    localparam int IDX_W     = $clog2(NREG);
    localparam int ERR_ADDR  = 0;
    localparam int FLAG_ADDR = 1;

    logic                           err_q;
    logic [NREG-1:0][DATA_W-1:0]    rd_vec;
    logic                           w_in_range;
    logic                           r_in_range;

    assign w_in_range = (waddr_i[DATA_W-1:IDX_W] == '0);
    assign r_in_range = (raddr_i[DATA_W-1:IDX_W] == '0);

    // Hold the tag-error flag until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_i) begin
            err_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == ERR_ADDR) begin : g_err
            assign rd_vec[i] = {{(DATA_W-1){1'b0}}, err_q};
        end else if (i == FLAG_ADDR) begin : g_flag
            assign rd_vec[i] = {{(DATA_W-FLAG_W){1'b0}}, flags_i};
        end else begin : g_rw
            logic [DATA_W-1:0] q;
            // Store host data when this register is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (we_i && w_in_range &&
                             waddr_i[IDX_W-1:0] == IDX_W'(i)) begin
                    q <= wdata_i;
                end
            end
            assign rd_vec[i] = q;
        end
    end

    assign rd_data_o   = r_in_range ? rd_vec[raddr_i[IDX_W-1:0]] : '0;
    assign test_ctrl_o = rd_vec[TEST_ADDR];

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R9
    AST_TEST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && waddr_i == DATA_W'(TEST_ADDR)) |=> test_ctrl_o == $past(wdata_i)); // R4
    AST_TEST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(test_ctrl_o)); // R5

endmodule

// File: rtl/regport_top.sv
// Module: top of the tagged shared-bus register port. Joins the warm-up
// counter, the phase sequencer and the register bank. The pad tri-state
// buffer sits outside and uses bus_out and bus_oe.
module regport_top #(
    parameter int DATA_W     = 8,
    parameter int NREG       = 16,
    parameter int FLAG_W     = 5,
    parameter int INIT_EDGES = 3,
    parameter int TEST_ADDR  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_anc,
    input  logic              dir_rd,
    input  logic [DATA_W+1:0] bus_in,
    output logic [DATA_W+1:0] bus_out,
    output logic              bus_oe,
    input  logic [FLAG_W-1:0] stat_flags,
    output logic [DATA_W-1:0] test_ctrl
);
    logic              ready;
    logic              we;
    logic              err;
    logic [DATA_W-1:0] raddr;
    logic [DATA_W-1:0] waddr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rd_data;

    regport_init #(.INIT_EDGES(INIT_EDGES)) u_init (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready_o (ready)
    );

    regport_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_i   (ready),
        .sel_anc   (sel_anc),
        .dir_rd    (dir_rd),
        .bus_in    (bus_in),
        .rd_data_i (rd_data),
        .raddr_o   (raddr),
        .we_o      (we),
        .waddr_o   (waddr),
        .wdata_o   (wdata),
        .err_o     (err),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe)
    );

    regport_bank #(
        .DATA_W    (DATA_W),
        .NREG      (NREG),
        .FLAG_W    (FLAG_W),
        .TEST_ADDR (TEST_ADDR)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (we),
        .waddr_i     (waddr),
        .wdata_i     (wdata),
        .err_i       (err),
        .raddr_i     (raddr),
        .flags_i     (stat_flags),
        .rd_data_o   (rd_data),
        .test_ctrl_o (test_ctrl)
    );

    AST_IN_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !bus_oe && bus_out == '0 && test_ctrl == '0); // R1

endmodule

// File: tb/regport_top_tb_top.sv
// Bench: a vector table of writes and reads walked by one loop, then
// directed tests for reset, warm-up, mode select, tag errors.
module regport_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_anc = 1'b1;
    logic       dir_rd = 1'b0;
    logic [9:0] bus_in = '0;
    logic [9:0] bus_out;
    logic       bus_oe;
    logic [4:0] stat_flags = 5'h15;
    logic [7:0] test_ctrl;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    regport_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_anc    (sel_anc),
        .dir_rd     (dir_rd),
        .bus_in     (bus_in),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .stat_flags (stat_flags),
        .test_ctrl  (test_ctrl)
    );

    // op[24] 1=write 0=read, addr[23:16], data[15:8], expected[7:0]
    localparam int NVEC = 16;
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 8'h02, 8'h5A, 8'h00},
        {1'b1, 8'h0D, 8'h27, 8'h00},
        {1'b1, 8'h0F, 8'hFF, 8'h00},
        {1'b1, 8'h03, 8'h81, 8'h00},
        {1'b0, 8'h02, 8'h00, 8'h5A},
        {1'b0, 8'h0D, 8'h00, 8'h27},
        {1'b0, 8'h0F, 8'h00, 8'hFF},
        {1'b0, 8'h03, 8'h00, 8'h81},
        {1'b1, 8'h13, 8'h66, 8'h00},
        {1'b0, 8'h13, 8'h00, 8'h00},
        {1'b0, 8'h03, 8'h00, 8'h81},
        {1'b1, 8'h00, 8'hFF, 8'h00},
        {1'b0, 8'h00, 8'h00, 8'h00},
        {1'b1, 8'h01, 8'hFF, 8'h00},
        {1'b0, 8'h01, 8'h00, 8'h15},
        {1'b0, 8'hFF, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read access; checks drive value, hold and release.
    task automatic do_rd(input logic [7:0] addr, input logic [1:0] tag_a,
                         output logic oe_act, output logic [9:0] d_act);
        @(negedge clk);
        sel_anc = 1'b0; dir_rd = 1'b1; bus_in = {tag_a, addr};
        @(negedge clk);
        oe_act = bus_oe; d_act = bus_out;
        bus_in = '0; sel_anc = 1'b1;
        #8;
        chk("R3 hold", bus_out, d_act);
        @(negedge clk);
        chk("R3 release", {bus_oe, bus_out[8:0]}, 10'h000);
    endtask

    // Write access; anc_mid raises sel_anc during the data phase.
    task automatic do_wr(input logic [7:0] addr, input logic [7:0] data,
                         input logic [1:0] tag_d, input logic anc_mid);
        @(negedge clk);
        sel_anc = 1'b0; dir_rd = 1'b0; bus_in = {2'b00, addr};
        @(negedge clk);
        sel_anc = anc_mid; bus_in = {tag_d, data};
        @(negedge clk);
        sel_anc = 1'b1; bus_in = '0;
    endtask

    task automatic apply_reset;
        rst_n = 1'b0; sel_anc = 1'b1; bus_in = '0;
        repeat (3) @(negedge clk);
        chk("R1 oe/out in reset", {bus_oe, bus_out[8:0]}, 10'h000);
        chk("R1 test_ctrl in reset", {2'b00, test_ctrl}, 10'h000);
        rst_n = 1'b1;
    endtask

    task automatic skip_init;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic       oe_a;
        logic [9:0] d_a;
        string      rq;

        // R1 reset state; R2 warm-up edges ignored
        apply_reset();
        sel_anc = 1'b0; dir_rd = 1'b1; bus_in = {2'b00, 8'h01};
        for (int e = 1; e <= 3; e++) begin
            @(negedge clk);
            chk($sformatf("R2 ignored edge %0d", e), {bus_oe, 9'h000}, 10'h000);
        end
        @(negedge clk);
        chk("R2 fourth edge accepted", {bus_oe, 9'h000}, 10'h200);
        chk("R3 R6 flag read data", bus_out, {2'b10, 8'h15});
        sel_anc = 1'b1; bus_in = '0;
        @(negedge clk);
        chk("R3 bus released", {bus_oe, bus_out[8:0]}, 10'h000);

        // table walk: R4 writes, R6 read-only, R7 unimplemented
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][23:16] >= 8'h10) rq = "R7";
            else if (VEC[v][23:16] < 8'h02) rq = "R6";
            else rq = "R4";
            if (VEC[v][24]) begin
                do_wr(VEC[v][23:16], VEC[v][15:8], 2'b11, 1'b0);
            end else begin
                do_rd(VEC[v][23:16], 2'b00, oe_a, d_a);
                chk($sformatf("%s vec %0d oe", rq, v), {oe_a, 9'h000}, 10'h200);
                chk($sformatf("%s vec %0d data", rq, v), d_a, {2'b10, VEC[v][7:0]});
            end
        end
        chk("R4 test_ctrl mirrors 0x0D", {2'b00, test_ctrl}, 10'h027);

        // R5 repeated reads are non-destructive
        for (int k = 0; k < 3; k++) begin
            do_rd(8'h0D, 2'b00, oe_a, d_a);
            chk($sformatf("R5 reread %0d", k), d_a, {2'b10, 8'h27});
        end

        // R6 flags sampled live at address edge
        stat_flags = 5'h0A;
        do_rd(8'h01, 2'b00, oe_a, d_a);
        chk("R6 new flags", d_a, {2'b10, 8'h0A});
        stat_flags = 5'h15;

        // R8 mode high: read ignored, pending write dropped, no error
        @(negedge clk);
        sel_anc = 1'b1; dir_rd = 1'b1; bus_in = {2'b00, 8'h02};
        @(negedge clk);
        chk("R8 no drive while ancillary", {bus_oe, bus_out[8:0]}, 10'h000);
        bus_in = '0;
        do_wr(8'h04, 8'hC3, 2'b11, 1'b1);
        do_rd(8'h04, 2'b00, oe_a, d_a);
        chk("R8 aborted write not stored", d_a, {2'b10, 8'h00});
        do_rd(8'h00, 2'b00, oe_a, d_a);
        chk("R8 no error flag", d_a, {2'b10, 8'h00});

        // R9 wrong address tag, then wrong data tag
        do_rd(8'h02, 2'b11, oe_a, d_a);
        chk("R9 bad address tag not driven", {oe_a, 9'h000}, 10'h000);
        do_wr(8'h05, 8'hAA, 2'b10, 1'b0);
        do_rd(8'h05, 2'b00, oe_a, d_a);
        chk("R9 bad data tag not stored", d_a, {2'b10, 8'h00});
        do_rd(8'h00, 2'b00, oe_a, d_a);
        chk("R9 error flag set", d_a, {2'b10, 8'h01});
        do_rd(8'h00, 2'b00, oe_a, d_a);
        chk("R9 error flag sticky", d_a, {2'b10, 8'h01});

        // R1 second reset clears bank and error
        apply_reset();
        skip_init();
        do_rd(8'h00, 2'b00, oe_a, d_a);
        chk("R1 error cleared by reset", d_a, {2'b10, 8'h00});
        do_rd(8'h0D, 2'b00, oe_a, d_a);
        chk("R1 register cleared by reset", d_a, {2'b10, 8'h00});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule